// File: doc/BRIEF.md
# SCSI REQ/ACK Transfer Controller

This block moves bytes across a SCSI bus during the information-transfer phases. It plays the target role: it drives REQ, samples ACK, and drives or samples the 8-bit data lines according to the transfer direction. On the local side, bytes pass through a single holding register. A processor reaches that register with read and write strobes (program mode), or a DMA engine reaches it through a DREQ/DACK handshake.

Each target ID has a stored entry that selects asynchronous or synchronous transfer, a REQ period in clock cycles and a maximum offset. A `start` pulse latches the entry for the selected ID, together with the phase code and the transfer length. The length is the block length multiplied by the block count. Only a data phase may run synchronously. Command, status and message phases always use the fully interlocked handshake, whatever the table says. The transfer ends with a one-cycle `done` once every byte has crossed the bus and every REQ has been answered.

Top module: `scsi_xfer_ctl`

## Requirements
- R1: After reset, `req_o`, `busy`, `done`, `dreq` and `hold_full` are low, `xfer_left` is zero, and every table entry selects asynchronous transfer.
- R2: One cycle after an accepted `start`, `busy` is high and `xfer_left` equals `blk_len * blk_cnt`. `xfer_left` then drops by one for each REQ issued.
- R3: Asynchronous, `phase[0]`=1 (target sends): REQ rises only while ACK is low and a byte is held, with that byte on `bus_do`. REQ falls only after ACK is seen high. The next REQ waits for ACK to go low.
- R4: Asynchronous, `phase[0]`=0 (target receives): REQ is raised while the holding register is empty. `bus_di` is captured when ACK is seen high, and the bytes reach `loc_rdata` in bus order.
- R5: When `phase[2:1]` is not `00` (command, status, message), the transfer is asynchronous even if the table entry for the ID selects synchronous.
- R6: Synchronous: successive REQ rises are at least `period` cycles apart, exactly `period` apart when nothing stalls, and each REQ pulse is high for `period/2` cycles. A period below 2 counts as 2.
- R7: Synchronous, target sending: the number of REQ pulses not yet matched by an ACK rise never exceeds the ID's offset (capped at 32). Pulses pause at that limit.
- R8: The table entry is copied when `start` is accepted. A configuration write during a transfer changes later transfers only.
- R9: `dreq` is high only in DMA mode on a data phase while busy. When sending, it requires an empty holding register and local bytes still to supply. When receiving, it requires a full holding register.
- R10: Completion raises `done` for one cycle and lowers `busy` in the same cycle. This happens once no REQ remains to issue, no ACK is outstanding, the handshake is idle and the holding register is empty.
- R11: A zero-length transfer raises `done` two cycles after `start` and issues no REQ.
- R12: Synchronous, target receiving: a new REQ is issued only when the holding register is empty and no ACK is outstanding, so at most one REQ is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the per-ID table |
| cfg_id | input | 3 | Table entry to write |
| cfg_sync | input | 1 | 1 = synchronous allowed for this ID |
| cfg_period | input | 8 | Synchronous REQ period in clock cycles |
| cfg_offset | input | 6 | Maximum outstanding REQs (0 = asynchronous) |
| start | input | 1 | Begin a transfer (ignored while busy) |
| phase | input | 3 | Phase code; [2:1]=00 is data, [0]=1 means target sends |
| tgt_id | input | 3 | ID whose table entry is applied |
| use_dma | input | 1 | 1 = DMA handshake for the data phase |
| blk_len | input | 16 | Block length in bytes |
| blk_cnt | input | 16 | Number of blocks |
| pio_wr | input | 1 | Processor write of `loc_wdata` into the holding register |
| pio_rd | input | 1 | Processor read of the holding register |
| loc_wdata | input | 8 | Local byte in |
| loc_rdata | output | 8 | Holding register contents |
| hold_full | output | 1 | Holding register contains a byte |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge; moves one byte in the same cycle |
| req_o | output | 1 | REQ to the bus |
| ack_i | input | 1 | ACK from the bus |
| bus_do | output | 8 | Data driven to the bus |
| bus_di | input | 8 | Data sampled from the bus |
| bus_oe | output | 1 | Enable for the data drivers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| xfer_left | output | 32 | REQs still to be issued |

## Verification
All inputs change on the falling clock edge and all outputs are sampled there. A `start` driven at one falling edge shows as `busy` and the new `xfer_left` at the next falling edge. A local write shows as `hold_full` one edge later. An ACK raised at a falling edge takes effect on REQ, capture and the outstanding count at the following rising edge, so REQ is observed to fall one sample after the ACK was driven. `dreq` and `req_o` are decoded from registers only, so the bench compares `dreq` against its own prediction at every sample. It times REQ pulse widths and rise-to-rise gaps in whole samples, and it tallies outstanding REQs from the edges it sees against the ACKs it has issued. End-of-transfer checks wait for `done` and read `busy` and `xfer_left` in that same sample. For a zero length, `done` is expected at exactly the second sample after `start`.

// File: rtl/scsi_xfer_ctl.sv
module scsi_xfer_ctl #(
  parameter int ID_W    = 3,
  parameter int LEN_W   = 16,
  parameter int RATE_W  = 8,
  parameter int OFF_W   = 6,
  parameter int MAX_OFF = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ID_W-1:0]      cfg_id,
  input  logic                 cfg_sync,
  input  logic [RATE_W-1:0]    cfg_period,
  input  logic [OFF_W-1:0]     cfg_offset,
  input  logic                 start,
  input  logic [2:0]           phase,
  input  logic [ID_W-1:0]      tgt_id,
  input  logic                 use_dma,
  input  logic [LEN_W-1:0]     blk_len,
  input  logic [LEN_W-1:0]     blk_cnt,
  input  logic                 pio_wr,
  input  logic                 pio_rd,
  input  logic [7:0]           loc_wdata,
  output logic [7:0]           loc_rdata,
  output logic                 hold_full,
  output logic                 dreq,
  input  logic                 dack,
  output logic                 req_o,
  input  logic                 ack_i,
  output logic [7:0]           bus_do,
  input  logic [7:0]           bus_di,
  output logic                 bus_oe,
  output logic                 busy,
  output logic                 done,
  output logic [2*LEN_W-1:0]   xfer_left
);
  localparam int NID   = 1 << ID_W;
  localparam int TOT_W = 2 * LEN_W;
  localparam logic [OFF_W-1:0]  OFF_CAP = OFF_W'(MAX_OFF);
  localparam logic [RATE_W-1:0] PER_MIN = RATE_W'(2);

  typedef enum logic [1:0] {A_IDLE, A_REQ, A_REL} ast_t;

  logic              tab_sync [NID];
  logic [RATE_W-1:0] tab_per  [NID];
  logic [OFF_W-1:0]  tab_off  [NID];

  logic              cur_data, cur_sync, cur_dma, dir_in;
  logic [RATE_W-1:0] cur_per, s_cnt;
  logic [OFF_W-1:0]  cur_off, outst;
  logic [TOT_W-1:0]  to_send, loc_left;
  logic [7:0]        hold;
  logic              s_act, ack_q;
  ast_t              a_st;

  wire start_ok = start && !busy;
  wire data_ph  = phase[2:1] == 2'b00;
  wire [TOT_W-1:0] total = TOT_W'(blk_len) * TOT_W'(blk_cnt);
  wire [RATE_W-1:0] id_per = tab_per[tgt_id] < PER_MIN ? PER_MIN : tab_per[tgt_id];
  wire [OFF_W-1:0]  id_off = tab_off[tgt_id] > OFF_CAP ? OFF_CAP : tab_off[tgt_id];

  wire ack_rise  = ack_i && !ack_q;
  wire more      = to_send != '0;
  wire loc_wr    = cur_dma ? dack : pio_wr;
  wire loc_rd    = cur_dma ? dack : pio_rd;
  wire loc_fill  = busy && dir_in && loc_wr && !hold_full && loc_left != '0;
  wire loc_drain = busy && !dir_in && loc_rd && hold_full;
  wire [RATE_W-1:0] s_hi = cur_per >> 1;
  wire s_slot    = !s_act || s_cnt == cur_per - RATE_W'(1);

  wire s_launch = busy && cur_sync && s_slot && more &&
                  (dir_in ? (hold_full && outst < cur_off) : (!hold_full && outst == '0));
  wire a_launch = busy && !cur_sync && a_st == A_IDLE && !ack_i && more &&
                  (dir_in ? hold_full : !hold_full);
  wire launch   = s_launch || a_launch;
  wire s_ack    = busy && cur_sync && ack_rise && outst != '0;
  wire bus_fill = busy && !dir_in && (cur_sync ? s_ack : (a_st == A_REQ && ack_i));
  wire finish   = busy && !more && outst == '0 && a_st == A_IDLE && !s_act && !hold_full;

  assign loc_rdata = hold;
  assign bus_oe    = busy && dir_in;
  assign xfer_left = to_send;
  assign dreq      = busy && cur_dma && (dir_in ? (!hold_full && loc_left != '0) : hold_full);
  assign req_o     = cur_sync ? (s_act && s_cnt < s_hi) : (a_st == A_REQ);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NID; i++) begin
        tab_sync[i] <= 1'b0;
        tab_per[i]  <= '0;
        tab_off[i]  <= '0;
      end
    end else if (cfg_we) begin
      tab_sync[cfg_id] <= cfg_sync;
      tab_per[cfg_id]  <= cfg_period;
      tab_off[cfg_id]  <= cfg_offset;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;  done <= 1'b0;
      cur_data <= 1'b0; cur_sync <= 1'b0; cur_dma <= 1'b0; dir_in <= 1'b0;
      cur_per <= PER_MIN; cur_off <= '0;
      to_send <= '0; loc_left <= '0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        busy     <= 1'b1;
        cur_data <= data_ph;
        dir_in   <= phase[0];
        cur_dma  <= use_dma && data_ph;
        cur_sync <= data_ph && tab_sync[tgt_id] && tab_off[tgt_id] != '0;
        cur_per  <= id_per;
        cur_off  <= id_off;
        to_send  <= total;
        loc_left <= total;
      end else begin
        if (launch)   to_send  <= to_send - TOT_W'(1);
        if (loc_fill) loc_left <= loc_left - TOT_W'(1);
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; bus_do <= '0;
    end else if (start_ok) begin
      hold_full <= 1'b0;
    end else if (loc_fill) begin
      hold <= loc_wdata; hold_full <= 1'b1;
    end else if (bus_fill) begin
      hold <= bus_di; hold_full <= 1'b1;
    end else if (launch && dir_in) begin
      bus_do <= hold; hold_full <= 1'b0;
    end else if (loc_drain) begin
      hold_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      outst <= '0; s_act <= 1'b0; s_cnt <= '0; ack_q <= 1'b0; a_st <= A_IDLE;
    end else begin
      ack_q <= ack_i;
      if (start_ok)              outst <= '0;
      else if (s_launch && !s_ack) outst <= outst + OFF_W'(1);
      else if (s_ack && !s_launch) outst <= outst - OFF_W'(1);

      if (start_ok) begin
        s_act <= 1'b0; s_cnt <= '0;
      end else if (s_launch) begin
        s_act <= 1'b1; s_cnt <= '0;
      end else if (s_act) begin
        if (s_cnt == cur_per - RATE_W'(1)) s_act <= 1'b0;
        else s_cnt <= s_cnt + RATE_W'(1);
      end

      case (a_st)
        A_IDLE:  if (a_launch) a_st <= A_REQ;
        A_REQ:   if (ack_i) a_st <= A_REL;
        default: if (!ack_i) a_st <= A_IDLE;
      endcase
    end

  // R7
  off_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cur_sync |-> outst <= cur_off) else $error("outstanding above offset");

  // R3
  interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) && !cur_sync |-> $past(!ack_i)) else $error("REQ rose with ACK high");

  // R5
  async_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cur_data |-> !cur_sync) else $error("non-data phase synchronous");

  // R9
  dreq_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> busy && (dir_in ? !hold_full : hold_full)) else $error("dreq out of turn");

  // R10
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && xfer_left == '0 && !req_o) else $error("done with work left");

  // R12
  rcv_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cur_sync && !dir_in |-> outst <= OFF_W'(1) && !(hold_full && outst != '0))
    else $error("receive overran holding register");

endmodule

// File: tb/sim_scsi_xfer_ctl.sv
module sim_scsi_xfer_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sync = 0, start = 0, use_dma = 0;
  logic pio_wr = 0, pio_rd = 0, dack = 0, ack_i = 0;
  logic [2:0] cfg_id = 0, tgt_id = 0, phase = 0;
  logic [7:0] cfg_period = 0, loc_wdata = 0, bus_di = 0;
  logic [5:0] cfg_offset = 0;
  logic [15:0] blk_len = 0, blk_cnt = 0;
  logic [7:0] loc_rdata, bus_do;
  logic hold_full, dreq, req_o, bus_oe, busy, done;
  logic [31:0] xfer_left;

  scsi_xfer_ctl u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
    .cfg_sync(cfg_sync), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
    .start(start), .phase(phase), .tgt_id(tgt_id), .use_dma(use_dma),
    .blk_len(blk_len), .blk_cnt(blk_cnt), .pio_wr(pio_wr), .pio_rd(pio_rd),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .hold_full(hold_full),
    .dreq(dreq), .dack(dack), .req_o(req_o), .ack_i(ack_i), .bus_do(bus_do),
    .bus_di(bus_di), .bus_oe(bus_oe), .busy(busy), .done(done), .xfer_left(xfer_left));

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((s + i * 37) & 255);
  endfunction

  // run description, written by the initial block only
  int run_id = 0;
  bit m_in, m_dma, m_sync;
  int m_per, m_off, m_tot, m_seed, m_lag;
  string m_tag = "R1";

  // monitor state, written by the always block only
  int seen_run = 0, cyc = 0, pend, maxp, wr_n, rdi, hi_cnt, last_rise, mingap, ack_after;
  int mon_checks = 0, mon_fails = 0;
  logic req_prev = 0;
  logic [7:0] rxq[$], lq[$];

  int checks = 0, failures = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic mon_chk(bit ok, string req, longint act, longint exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    bit exp_dreq, rise, fall;
    cyc++;
    if (cyc >= 150000) begin
      mon_fails++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
      $finish;
    end
    if (seen_run != run_id) begin
      seen_run = run_id;
      pend = 0; maxp = 0; wr_n = 0; rdi = 0; hi_cnt = 0;
      last_rise = -1; mingap = 1 << 30; ack_after = cyc + m_lag;
      rxq.delete(); lq.delete();
    end
    pio_wr = 0; pio_rd = 0; dack = 0;
    if (rst_n) begin
      // R9: DMA request predicted from the holding state and local progress
      exp_dreq = busy && m_dma && (m_in ? (!hold_full && wr_n < m_tot) : hold_full);
      mon_chk(dreq === exp_dreq, "R9", dreq, exp_dreq);

      rise = req_o && !req_prev;
      fall = !req_o && req_prev;
      if (rise) begin
        pend++;
        if (pend > maxp) maxp = pend;
        mon_chk(pend <= m_off, m_tag, pend, m_off);
        if (m_in) rxq.push_back(bus_do);
        if (m_sync) begin
          if (last_rise >= 0) begin
            mon_chk(cyc - last_rise >= m_per, "R6", cyc - last_rise, m_per);
            if (cyc - last_rise < mingap) mingap = cyc - last_rise;
          end
          last_rise = cyc;
          hi_cnt = 1;
        end else
          mon_chk(ack_i == 1'b0, m_tag, ack_i, 0);
      end else if (req_o) hi_cnt++;
      if (fall) begin
        if (m_sync) mon_chk(hi_cnt == m_per / 2, "R6", hi_cnt, m_per / 2);
        else mon_chk(ack_i == 1'b1, m_tag, ack_i, 1);
      end

      // initiator model
      if (!m_sync) begin
        if (req_o && !ack_i) begin
          if (!m_in) begin bus_di = pat(rdi, m_seed); rdi++; end
          ack_i = 1; pend--;
        end else if (!req_o && ack_i) ack_i = 0;
      end else begin
        if (ack_i) ack_i = 0;
        else if (pend > 0 && cyc >= ack_after) begin
          if (!m_in) begin bus_di = pat(rdi, m_seed); rdi++; end
          ack_i = 1; pend--;
        end
      end

      // local side model
      if (busy) begin
        if (m_in) begin
          if (wr_n < m_tot && (m_dma ? dreq : !hold_full)) begin
            loc_wdata = pat(wr_n, m_seed);
            if (m_dma) dack = 1; else pio_wr = 1;
            wr_n++;
          end
        end else if (m_dma ? dreq : hold_full) begin
          lq.push_back(loc_rdata);
          if (m_dma) dack = 1; else pio_rd = 1;
        end
      end
    end
    req_prev = req_o;
  end

  task automatic set_cfg(int id, bit s, int per, int off);
    @(negedge clk);
    cfg_we = 1; cfg_id = 3'(id); cfg_sync = s; cfg_period = 8'(per); cfg_offset = 6'(off);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_xfer(logic [2:0] ph, int id, bit dma, int len, int cnt, bit sync_exp,
                          int per, int off_exp, int lag, int seed, bit mid_cfg, string tag);
    int waited;
    bit seen;
    m_in = ph[0]; m_dma = dma; m_sync = sync_exp; m_per = per; m_off = off_exp;
    m_tot = len * cnt; m_seed = seed; m_lag = lag; m_tag = tag;
    run_id++;
    @(negedge clk);
    phase = ph; tgt_id = 3'(id); use_dma = dma; blk_len = 16'(len); blk_cnt = 16'(cnt);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2", busy, 1);
    chk(xfer_left == 32'(m_tot), "R2", xfer_left, m_tot);
    waited = 0; seen = 0;
    while (!seen && waited < 4000) begin
      @(negedge clk);
      waited++;
      cfg_we = 0;
      if (mid_cfg && waited == 5) begin
        // R8: rewrite this ID while the transfer runs
        cfg_we = 1; cfg_id = 3'(id); cfg_sync = 1; cfg_period = 8'(per); cfg_offset = 6'd1;
      end
      if (done) seen = 1;
    end
    cfg_we = 0;
    chk(seen, "R10", seen, 1);
    chk(busy == 1'b0, "R10", busy, 0);
    chk(xfer_left == 0, "R10", xfer_left, 0);
    if (m_tot == 0) chk(waited == 1, "R11", waited, 1);
    if (m_in) begin
      chk(rxq.size() == m_tot, tag, rxq.size(), m_tot);
      foreach (rxq[i]) chk(rxq[i] == pat(i, seed), tag, rxq[i], pat(i, seed));
    end else begin
      chk(lq.size() == m_tot, tag, lq.size(), m_tot);
      foreach (lq[i]) chk(lq[i] == pat(i, seed), tag, lq[i], pat(i, seed));
    end
    chk(maxp == off_exp, tag, maxp, off_exp);
    if (sync_exp && m_in && off_exp > 1) chk(mingap == per, "R6", mingap, per);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_o == 0, "R1", req_o, 0);
    chk(busy == 0, "R1", busy, 0);
    chk(done == 0, "R1", done, 0);
    chk(dreq == 0, "R1", dreq, 0);
    chk(hold_full == 0, "R1", hold_full, 0);
    chk(xfer_left == 0, "R1", xfer_left, 0);
    // R1: an unwritten ID runs a data phase asynchronously
    run_xfer(3'b001, 6, 0, 2, 1, 0, 0, 1, 0, 3, 0, "R1");

    set_cfg(2, 1, 6, 4);
    set_cfg(5, 0, 0, 0);
    set_cfg(3, 1, 4, 8);

    // R5: command phase to a synchronous ID stays interlocked
    run_xfer(3'b010, 2, 0, 3, 1, 0, 0, 1, 0, 11, 0, "R5");
    // R3: asynchronous send, program mode, 4 x 2 bytes
    run_xfer(3'b001, 5, 0, 4, 2, 0, 0, 1, 0, 23, 0, "R3");
    // R4: asynchronous receive, DMA mode
    run_xfer(3'b000, 5, 1, 5, 1, 0, 0, 1, 0, 41, 0, "R4");
    // R7: synchronous send, DMA, slow ACKs reach offset 4; R8 write lands mid-run
    run_xfer(3'b001, 2, 1, 10, 2, 1, 6, 4, 60, 57, 1, "R7");
    // R8: the rewritten entry (offset 1) applies to the next transfer
    run_xfer(3'b001, 2, 0, 3, 2, 1, 6, 1, 40, 71, 0, "R8");
    // R12: synchronous receive keeps one REQ outstanding despite offset 8
    run_xfer(3'b000, 3, 0, 6, 1, 1, 4, 1, 0, 83, 0, "R12");
    // R5: status phase to a synchronous ID
    run_xfer(3'b011, 3, 0, 2, 1, 0, 0, 1, 0, 97, 0, "R5");
    // R11: zero block count
    run_xfer(3'b001, 3, 1, 7, 0, 1, 4, 0, 0, 5, 0, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
    $finish;
  end
endmodule